// File: doc/BRIEF.md
# Interrupt Level Priority Selector

This block decides which processor interrupt level is offered to the CPU. Fifteen external request lines, numbered 1 to 15, are each raised or lowered by separate set and clear strobes. They are held in a level register. A 16-bit soft-interrupt status value is registered beside them. Bit 0 of that value is the timer soft interrupt, and it is folded onto level 14. The other soft bits 1 to 15 feed their own levels directly. The highest pending level is turned into a 9-bit trap index, `0x40 | level`, and is presented on `trap_idx` together with a hard-interrupt request.

A small presentation state machine holds the index the CPU currently sees. It has three states:
- `ST_IDLE`: the index is zero.
- `ST_EXT`: an external-interrupt trap is presented, meaning index bits [8:4] equal 4.
- `ST_OTHER`: the CPU has loaded some other trap index, which must not be overridden.

Its transitions are:
- IDLE→EXT (*present*) when any level is pending.
- EXT→EXT (*re-present*) when the winning level changes, which raises the request again.
- EXT→IDLE (*withdraw*) when nothing is pending.
- any→IDLE (*acknowledge*) on `cpu_ack`.
- any→IDLE/EXT/OTHER (*load*) on `cpu_load`, with the target state chosen by the loaded value.

In `ST_OTHER`, pending levels are ignored until the CPU acknowledges or loads again.

Top module: `irq_level_select`

## Requirements
- R1: After reset `trap_idx` is 0, `hard_req` is 0 and the state is `ST_IDLE`.
- R2: A 1 on `ext_set[n]` raises external level n, and a 1 on `ext_clr[n]` lowers it. When both strobes are 1 for the same bit in the same cycle, the set wins.
- R3: `soft_int[0]` (timer) makes level 14 pending. `soft_int[n]` for n in 1..15 makes level n pending.
- R4: Among pending levels 1..15, the highest number wins.
- R5: A presented index equals `0x40` ORed with the winning level in bits [3:0], on 9 bits.
- R6: While a loaded index whose bits [8:4] are neither 0 nor 4 is held (`ST_OTHER`), pending levels neither replace it nor clear it.
- R7: `hard_req` rises to 1 in the same edge that a new index differing from the held one is presented. It keeps its value while the index is unchanged. It is 1 only in `ST_EXT`.
- R8: In `ST_EXT`, when no level is pending, the index returns to 0 and `hard_req` to 0.
- R9: `cpu_ack` clears the index and `hard_req` at the next edge, and it takes priority over `cpu_load` in the same cycle.
- R10: `cpu_load` places `cpu_load_idx` into `trap_idx` at the next edge, with `hard_req` 0.
- R11: A change on `ext_set`, `ext_clr` or `soft_int` reaches `trap_idx` and `hard_req` at the second rising edge after it is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_set | input | 15 ([15:1]) | Per-level raise strobes for the external lines |
| ext_clr | input | 15 ([15:1]) | Per-level lower strobes for the external lines |
| soft_int | input | 16 | Soft-interrupt status value; bit 0 is the timer bit |
| cpu_ack | input | 1 | CPU took or cleared the trap; zeroes the index |
| cpu_load | input | 1 | CPU writes `cpu_load_idx` into the held index |
| cpu_load_idx | input | 9 | Index value written by `cpu_load` |
| trap_idx | output | 9 | Trap index presented to the CPU |
| hard_req | output | 1 | Hard-interrupt request |

## Verification
The line and soft-interrupt changes pass through the input register and then the index register. Their effect is therefore sampled on the falling edge after the second rising edge. One sample is also taken a cycle earlier to show that the index has not yet moved. `cpu_ack` and `cpu_load` act on the index register directly, so their results are sampled on the falling edge right after the first rising edge. A behavioural reference model, advanced on every rising edge, is compared on every falling edge. The directed checks compare against values worked out by hand, such as `0x4E` for a lone timer bit.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;

    // Presentation state: what kind of index the CPU currently sees.
    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_EXT   = 2'd1,
        ST_OTHER = 2'd2
    } pres_state_e;

endpackage

// File: rtl/irq_line_bank.sv
module irq_line_bank #(
    parameter int LEVELS = 16,
    parameter int SOFT_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:1] ext_set,
    input  logic [LEVELS-1:1] ext_clr,
    input  logic [SOFT_W-1:0] soft_in,
    output logic [LEVELS-1:1] ext_q,
    output logic [SOFT_W-1:0] soft_q
);

    // One flop per external level; a set strobe beats a clear strobe.
    for (genvar g = 1; g < LEVELS; g++) begin : g_line
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                ext_q[g] <= 1'b0;
            end else if (ext_set[g]) begin
                ext_q[g] <= 1'b1;
            end else if (ext_clr[g]) begin
                ext_q[g] <= 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            soft_q <= '0;
        end else begin
            soft_q <= soft_in;
        end
    end

    // R2
    set_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|ext_set) |=> ((ext_q & $past(ext_set)) == $past(ext_set)));

    // R2
    clr_lands_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(ext_clr & ~ext_set)) |=> ((ext_q & $past(ext_clr & ~ext_set)) == '0));

endmodule

// File: rtl/irq_level_merge.sv
module irq_level_merge #(
    parameter int LEVELS    = 16,
    parameter int SOFT_W    = 16,
    parameter int TIMER_LVL = 14,
    parameter int LVL_W     = $clog2(LEVELS)
) (
    input  logic [LEVELS-1:1] ext_q,
    input  logic [SOFT_W-1:0] soft_q,
    output logic              any_pend,
    output logic [LVL_W-1:0]  top_lvl
);

    logic [LEVELS-1:1] pend;

    // Soft bit 0 is the timer source: it is masked from its own position
    // and folded onto TIMER_LVL instead.
    for (genvar g = 1; g < LEVELS; g++) begin : g_lvl
        if (g == TIMER_LVL) begin : g_tmr
            assign pend[g] = ext_q[g] | soft_q[g] | soft_q[0];
        end else if (g < SOFT_W) begin : g_soft
            assign pend[g] = ext_q[g] | soft_q[g];
        end else begin : g_ext
            assign pend[g] = ext_q[g];
        end
    end

    // Highest numbered pending level wins; later iterations override.
    always_comb begin
        top_lvl = '0;
        for (int l = 1; l < LEVELS; l++) begin
            if (pend[l]) begin
                top_lvl = LVL_W'(l);
            end
        end
    end

    assign any_pend = |pend;

endmodule

// File: rtl/irq_present_fsm.sv
module irq_present_fsm
    import irq_sel_pkg::*;
#(
    parameter int             IDX_W    = 9,
    parameter int             LVL_W    = 4,
    parameter logic [IDX_W-1:0] EXT_BASE = 9'h040
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             any_pend,
    input  logic [LVL_W-1:0] top_lvl,
    input  logic             cpu_ack,
    input  logic             cpu_load,
    input  logic [IDX_W-1:0] cpu_load_idx,
    output logic [IDX_W-1:0] trap_idx,
    output logic             hard_req
);

    localparam int HI_W = IDX_W - LVL_W;
    localparam logic [HI_W-1:0] BASE_HI = EXT_BASE[IDX_W-1:LVL_W];

    pres_state_e       state_q, state_n;
    logic [IDX_W-1:0]  idx_q, idx_n;
    logic              req_q, req_n;
    logic [IDX_W-1:0]  cand;

    function automatic pres_state_e classify(input logic [IDX_W-1:0] v);
        if (v == '0) begin
            return ST_IDLE;
        end else if (v[IDX_W-1:LVL_W] == BASE_HI) begin
            return ST_EXT;
        end else begin
            return ST_OTHER;
        end
    endfunction

    assign cand = EXT_BASE | IDX_W'(top_lvl);

    always_comb begin
        state_n = state_q;
        idx_n   = idx_q;
        req_n   = req_q;
        if (cpu_ack) begin
            state_n = ST_IDLE;
            idx_n   = '0;
            req_n   = 1'b0;
        end else if (cpu_load) begin
            state_n = classify(cpu_load_idx);
            idx_n   = cpu_load_idx;
            req_n   = 1'b0;
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (any_pend) begin
                        state_n = ST_EXT;
                        idx_n   = cand;
                        req_n   = 1'b1;
                    end
                end
                ST_EXT: begin
                    if (!any_pend) begin
                        state_n = ST_IDLE;
                        idx_n   = '0;
                        req_n   = 1'b0;
                    end else if (cand != idx_q) begin
                        idx_n   = cand;
                        req_n   = 1'b1;
                    end
                end
                ST_OTHER: begin
                    state_n = ST_OTHER;
                end
                default: begin
                    state_n = ST_IDLE;
                    idx_n   = '0;
                    req_n   = 1'b0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_n;
        end
    end

    // Output registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
            req_q <= 1'b0;
        end else begin
            idx_q <= idx_n;
            req_q <= req_n;
        end
    end

    assign trap_idx = idx_q;
    assign hard_req = req_q;

    // R7
    req_only_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req |-> (state_q == ST_EXT));

    // R5
    req_level_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hard_req |-> (trap_idx[LVL_W-1:0] != '0 && trap_idx[IDX_W-1:LVL_W] == BASE_HI));

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> (trap_idx == '0 && !hard_req));

    // R6
    foreign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OTHER && !cpu_ack && !cpu_load) |=> $stable(trap_idx));

    // R8
    withdraw_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_EXT && !any_pend && !cpu_ack && !cpu_load) |=> (trap_idx == '0 && !hard_req));

    // R10
    load_takes_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_load && !cpu_ack) |=> (trap_idx == $past(cpu_load_idx) && !hard_req));

endmodule

// File: rtl/irq_level_select.sv
module irq_level_select
    import irq_sel_pkg::*;
#(
    parameter int               LEVELS    = 16,
    parameter int               SOFT_W    = 16,
    parameter int               TIMER_LVL = 14,
    parameter int               IDX_W     = 9,
    parameter logic [IDX_W-1:0] EXT_BASE  = 9'h040
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [LEVELS-1:1] ext_set,
    input  logic [LEVELS-1:1] ext_clr,
    input  logic [SOFT_W-1:0] soft_int,
    input  logic              cpu_ack,
    input  logic              cpu_load,
    input  logic [IDX_W-1:0]  cpu_load_idx,
    output logic [IDX_W-1:0]  trap_idx,
    output logic              hard_req
);

    localparam int LVL_W = $clog2(LEVELS);

    logic [LEVELS-1:1] ext_q;
    logic [SOFT_W-1:0] soft_q;
    logic              any_pend;
    logic [LVL_W-1:0]  top_lvl;

    irq_line_bank #(
        .LEVELS (LEVELS),
        .SOFT_W (SOFT_W)
    ) u_bank (
        .clk     (clk),
        .rst_n   (rst_n),
        .ext_set (ext_set),
        .ext_clr (ext_clr),
        .soft_in (soft_int),
        .ext_q   (ext_q),
        .soft_q  (soft_q)
    );

    irq_level_merge #(
        .LEVELS    (LEVELS),
        .SOFT_W    (SOFT_W),
        .TIMER_LVL (TIMER_LVL),
        .LVL_W     (LVL_W)
    ) u_merge (
        .ext_q    (ext_q),
        .soft_q   (soft_q),
        .any_pend (any_pend),
        .top_lvl  (top_lvl)
    );

    irq_present_fsm #(
        .IDX_W    (IDX_W),
        .LVL_W    (LVL_W),
        .EXT_BASE (EXT_BASE)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .any_pend     (any_pend),
        .top_lvl      (top_lvl),
        .cpu_ack      (cpu_ack),
        .cpu_load     (cpu_load),
        .cpu_load_idx (cpu_load_idx),
        .trap_idx     (trap_idx),
        .hard_req     (hard_req)
    );

endmodule

// File: tb/tb_irq_level_select.sv
`timescale 1ns/1ps
module tb_irq_level_select;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:1] ext_set = '0;
    logic [15:1] ext_clr = '0;
    logic [15:0] soft_int = '0;
    logic        cpu_ack = 1'b0;
    logic        cpu_load = 1'b0;
    logic [8:0]  cpu_load_idx = '0;
    logic [8:0]  trap_idx;
    logic        hard_req;

    int total = 0;
    int fails = 0;

    always #2.5 clk = ~clk;

    irq_level_select dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .ext_set      (ext_set),
        .ext_clr      (ext_clr),
        .soft_int     (soft_int),
        .cpu_ack      (cpu_ack),
        .cpu_load     (cpu_load),
        .cpu_load_idx (cpu_load_idx),
        .trap_idx     (trap_idx),
        .hard_req     (hard_req)
    );

    // Behavioural reference model, advanced every rising edge.
    logic [15:0] m_ext = '0;
    logic [15:0] m_soft = '0;
    int          m_idx = 0;
    logic        m_req = 1'b0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ext = '0; m_soft = '0; m_idx = 0; m_req = 1'b0;
        end else begin
            logic [15:0] pend;
            int lvl;
            pend = m_ext | (m_soft & 16'hFFFE);
            if (m_soft[0]) pend[14] = 1'b1;
            lvl = 0;
            for (int l = 15; l >= 1; l--) begin
                if (pend[l] && lvl == 0) lvl = l;
            end
            if (cpu_ack) begin
                m_idx = 0; m_req = 1'b0;
            end else if (cpu_load) begin
                m_idx = int'(cpu_load_idx); m_req = 1'b0;
            end else if (lvl != 0 && (m_idx == 0 || (m_idx >> 4) == 4)) begin
                if ((64 + lvl) != m_idx) begin
                    m_idx = 64 + lvl; m_req = 1'b1;
                end
            end else if (lvl == 0 && (m_idx >> 4) == 4) begin
                m_idx = 0; m_req = 1'b0;
            end
            for (int b = 1; b < 16; b++) begin
                if (ext_set[b]) m_ext[b] = 1'b1;
                else if (ext_clr[b]) m_ext[b] = 1'b0;
            end
            m_soft = soft_int;
        end
    end

    task automatic chk(input string tag, input logic [8:0] ai, input logic [8:0] ei,
                       input logic ar, input logic er);
        total++;
        if (ai !== ei || ar !== er) begin
            fails++;
            $display("FAIL %s: trap_idx=%h hard_req=%b expected trap_idx=%h hard_req=%b",
                     tag, ai, ar, ei, er);
        end
    endtask

    // R11: model comparison on every falling edge
    always @(negedge clk) begin
        if (rst_n) chk("R11 model", trap_idx, 9'(m_idx), hard_req, m_req);
    end

    // Strobe the lines for one cycle; returns on the falling edge after the second rising edge.
    task automatic pulse(input logic [15:1] s, input logic [15:1] c);
        ext_set = s; ext_clr = c;
        @(negedge clk);
        ext_set = '0; ext_clr = '0;
        @(negedge clk);
    endtask

    task automatic soft_to(input logic [15:0] v);
        soft_int = v;
        @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(100000 * 5);
        fails++; total++;
        $display("FAIL watchdog: run did not finish");
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", trap_idx, 9'h000, hard_req, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", trap_idx, 9'h000, hard_req, 1'b0);

        // R11: one cycle after the strobe nothing has moved yet
        ext_set = 15'(1 << 4);
        @(negedge clk);
        ext_set = '0;
        chk("R11", trap_idx, 9'h000, hard_req, 1'b0);
        @(negedge clk);
        // R2 R5 R7: level 5 presented
        chk("R5", trap_idx, 9'h045, hard_req, 1'b1);

        // R4: level 9 beats level 5
        pulse(15'(1 << 8), '0);
        chk("R4", trap_idx, 9'h049, hard_req, 1'b1);
        @(negedge clk);
        chk("R7", trap_idx, 9'h049, hard_req, 1'b1);

        // R9: acknowledge clears, then re-presentation
        cpu_ack = 1'b1;
        @(negedge clk);
        cpu_ack = 1'b0;
        chk("R9", trap_idx, 9'h000, hard_req, 1'b0);
        @(negedge clk);
        chk("R7", trap_idx, 9'h049, hard_req, 1'b1);

        // R8: everything lowered, index withdrawn
        pulse('0, 15'(1 << 8) | 15'(1 << 4));
        chk("R8", trap_idx, 9'h000, hard_req, 1'b0);

        // R3: timer bit maps to level 14, other soft bits map directly
        soft_to(16'h0001);
        chk("R3", trap_idx, 9'h04E, hard_req, 1'b1);
        soft_to(16'h0008);
        chk("R3", trap_idx, 9'h043, hard_req, 1'b1);
        soft_to(16'h8001);
        chk("R4", trap_idx, 9'h04F, hard_req, 1'b1);
        soft_to(16'h0000);
        chk("R8", trap_idx, 9'h000, hard_req, 1'b0);

        // R2: set and clear on the same bit, set wins
        pulse(15'(1 << 6), 15'(1 << 6));
        chk("R2", trap_idx, 9'h047, hard_req, 1'b1);
        pulse('0, 15'(1 << 6));
        chk("R2", trap_idx, 9'h000, hard_req, 1'b0);

        // R10: foreign index load
        cpu_load = 1'b1; cpu_load_idx = 9'h023;
        @(negedge clk);
        cpu_load = 1'b0;
        chk("R10", trap_idx, 9'h023, hard_req, 1'b0);
        // R6: pending level does not override the foreign index
        pulse(15'(1 << 11), '0);
        chk("R6", trap_idx, 9'h023, hard_req, 1'b0);
        pulse('0, 15'(1 << 11));
        @(negedge clk);
        chk("R6", trap_idx, 9'h023, hard_req, 1'b0);

        // R9: ack wins over load in the same cycle
        pulse(15'(1 << 1), '0);
        cpu_ack = 1'b1; cpu_load = 1'b1; cpu_load_idx = 9'h1A5;
        @(negedge clk);
        cpu_ack = 1'b0; cpu_load = 1'b0;
        chk("R9", trap_idx, 9'h000, hard_req, 1'b0);
        @(negedge clk);
        chk("R5", trap_idx, 9'h042, hard_req, 1'b1);
        pulse('0, 15'(1 << 1));
        chk("R8", trap_idx, 9'h000, hard_req, 1'b0);

        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", total - fails, total);
        $finish;
    end

endmodule